// File: doc/BRIEF.md
# Bidirectional Mailbox and Dual Interrupt Controller

This block passes single 32-bit messages between a host bus side and a local processor side. Each direction has its own mailbox register and its own "full" flag. The sender writes the mailbox, which raises the flag toward the receiver. The receiver's read of the mailbox drops the flag again, so software never has to acknowledge it by hand.

Each side has its own small interrupt controller. It holds a five-bit status register and a five-bit mask register, and it drives one interrupt line: any status bit whose mask bit is set raises that line.

Status bit positions:

| Bit | Source |
|-----|--------|
| 0 | Incoming mailbox full |
| 1 | DMA transfer done |
| 2 | FIFO not empty |
| 3 | FIFO overflow |
| 4 | Rising edge on an asynchronous external interrupt pin |

The DMA engine and the FIFOs live outside the block and appear only as event inputs. The event inputs and the external pin feed both sides. Each side clears its own copy independently.

Each side sees three registers through a two-bit address:

| Address | Register | Read | Write |
|---------|----------|------|-------|
| 0 | Mailbox | Returns the incoming mailbox | Loads the outgoing mailbox |
| 1 | Status | Returns the status bits | Clears status bits by writing 1 |
| 2 | Mask | Returns the mask | Loads the mask |

Read data is combinational from the address. A read strobe matters only at address 0.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: A write strobe at address 0 on one side loads the 32-bit data into that side's outgoing mailbox. On the next clock, bit 0 of the other side's status reads 1, and the other side reads the data at address 0.
- R2: A read strobe at address 0 clears the incoming mailbox's full flag at that clock edge. The mailbox data is left unchanged.
- R3: The local-to-host direction behaves exactly like the host-to-local direction: a local write raises host status bit 0, and a host read clears it.
- R4: Writing a mailbox again before it is read keeps its flag set, and the new data replaces the old.
- R5: When the sender's write and the receiver's read of the same mailbox fall in one cycle, the read returns the old data. After that edge the flag stays set and the mailbox holds the new data.
- R6: A high cycle on the event inputs sets status bits on both sides, and the bits stay set after the input drops. The inputs map as: dma_done to bit 1, fifo_nempty to bit 2, fifo_ovfl to bit 3.
- R7: Writing address 1 clears each of status bits 1 to 4 whose data bit is 1. Zero data bits leave their status bits alone. Bit 0 ignores status writes and follows only the mailbox.
- R8: An event that is high in the same cycle as a clear of its bit leaves that bit set.
- R9: The external pin passes through a two-flop synchronizer. Status bit 4 sets on the third rising clock edge after the pin goes high. A pin held high does not set the bit again after a clear.
- R10: The mask at address 2 stores data bits 4:0 and reads back as written. Each side's interrupt output is high exactly when its status AND its mask is nonzero.
- R11: After reset, all status and mask bits are 0, both mailboxes read 0, and both interrupt outputs are low.
- R12: A status clear or mask write on one side leaves the other side's status and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | 2 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (acts at address 0 only) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational from h_addr |
| h_irq | output | 1 | Host interrupt |
| l_addr | input | 2 | Local register address |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe (acts at address 0 only) |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, combinational from l_addr |
| l_irq | output | 1 | Local interrupt |
| dma_done | input | 1 | DMA completion event |
| fifo_nempty | input | 1 | FIFO not-empty event |
| fifo_ovfl | input | 1 | FIFO overflow event |
| ext_irq_pin | input | 1 | Asynchronous external interrupt pin |

## Verification
The interrupt combine is swept exhaustively on both sides.

- Every one of the 32 status patterns is built from real stimulus: mailbox writes, event pulses and pin pulses.
- Each pattern is read back, which shows that every source lands on its own bit.
- Each pattern is then paired with all 32 masks. This separates an OR-of-AND combine from a wrong bit order, a missing source or an inverted mask.

Directed sequences cover the harder timing cases:

- a mailbox rewrite before it is read, and a write and read in the same cycle;
- a clear that coincides with a new event;
- clear writes with zero and non-zero bits, which separate write-1-to-clear from a plain write;
- the edge-counted latency of the pin synchronizer, with the pin held high across a clear;
- a clear on one side while the other side's status is watched.

// File: rtl/mbox_irq_pkg.sv
// Package: shared constants and register selector for the mailbox/interrupt block.
// Assumes: five interrupt sources, with bit 0 reserved for the mailbox flag.
package mbox_irq_pkg;
    localparam int NSRC = 5;          // status/mask width
    localparam int NEV  = NSRC - 1;   // hardware event bits (1..4)

    typedef enum logic [1:0] {
        REG_MBOX = 2'd0,
        REG_STAT = 2'd1,
        REG_MASK = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mbox_ext_sync.sv
// Module: synchronizes an asynchronous pin and emits a one-cycle rise pulse.
// Assumes: the pin is slow compared with clk; STAGES >= 2.
module mbox_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    // Shift the pin through the synchronizer stages plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], pin_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/mbox_chan.sv
// Module: one mailbox direction, holding the data word and its full flag.
// Assumes: a write and a read in the same cycle leave the flag set (the write wins).
module mbox_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    output logic [DW-1:0] data_o,
    output logic          full_o
);
    // Load the data word on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_o <= '0;
        else if (wr_i) data_o <= wdata_i;
    end

    // Set the flag on a write, clear it on a read; a write has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    full_o <= 1'b0;
        else if (wr_i) full_o <= 1'b1;
        else if (rd_i) full_o <= 1'b0;
    end

    // R1
    wr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (full_o && data_o == $past(wdata_i)));
    // R2
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i) |=> !full_o);
    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(data_o));
endmodule

// File: rtl/mbox_irq_side.sv
// Module: one side's status and mask registers, interrupt combine and read mux.
// Assumes: status bit 0 mirrors the incoming mailbox flag; bits 1..NSRC-1 are sticky
// event bits cleared by writing 1; an event in the same cycle as its clear wins.
module mbox_irq_side
    import mbox_irq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      addr_i,
    input  logic            wr_i,
    input  logic [NSRC-1:0] wbits_i,
    input  logic            mbox_full_i,
    input  logic [DW-1:0]   mbox_data_i,
    input  logic [NEV-1:0]  ev_i,
    output logic [DW-1:0]   rdata_o,
    output logic            irq_o
);
    logic [NEV-1:0]  ev_q;
    logic [NSRC-1:0] mask_q;
    logic [NEV-1:0]  clr;
    logic [NSRC-1:0] status;

    assign clr    = (wr_i && addr_i == REG_STAT) ? wbits_i[NSRC-1:1] : '0;
    assign status = {ev_q, mbox_full_i};

    // Sticky event bits: set by an event, cleared by a write-1, with the event winning.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_i | (ev_q & ~clr);
    end

    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '0;
        else if (wr_i && addr_i == REG_MASK) mask_q <= wbits_i;
    end

    // Combine the enabled sources into one interrupt line.
    assign irq_o = |(status & mask_q);

    // Register read multiplexer.
    always_comb begin
        unique case (addr_i)
            REG_MBOX: rdata_o = mbox_data_i;
            REG_STAT: rdata_o = {{(DW-NSRC){1'b0}}, status};
            REG_MASK: rdata_o = {{(DW-NSRC){1'b0}}, mask_q};
            default:  rdata_o = '0;
        endcase
    end

    for (genvar g = 0; g < NEV; g++) begin : g_bit
        // R6
        ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[g] |=> ev_q[g]);
        // R7
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !ev_i[g]) |=> !ev_q[g]);
    end

    // R10
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/mbox_irq_ctrl.sv
// Module: top level, with two mailboxes and two interrupt controllers (host and local).
// Assumes: the event inputs are synchronous to clk; ext_irq_pin is asynchronous.
module mbox_irq_ctrl
    import mbox_irq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        h_addr,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq,
    input  logic [1:0]        l_addr,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq,
    input  logic              dma_done,
    input  logic              fifo_nempty,
    input  logic              fifo_ovfl,
    input  logic              ext_irq_pin
);
    logic              ext_rise;
    logic [NEV-1:0]    ev;
    logic              h2l_full;
    logic              l2h_full;
    logic [DATA_W-1:0] h2l_data;
    logic [DATA_W-1:0] l2h_data;
    logic              h_mbox_wr;
    logic              h_mbox_rd;
    logic              l_mbox_wr;
    logic              l_mbox_rd;

    assign h_mbox_wr = h_wr && h_addr == REG_MBOX;
    assign h_mbox_rd = h_rd && h_addr == REG_MBOX;
    assign l_mbox_wr = l_wr && l_addr == REG_MBOX;
    assign l_mbox_rd = l_rd && l_addr == REG_MBOX;
    assign ev        = {ext_rise, fifo_ovfl, fifo_nempty, dma_done};

    mbox_ext_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_irq_pin), .rise_o(ext_rise)
    );

    mbox_chan #(.DW(DATA_W)) i_h2l (
        .clk(clk), .rst_n(rst_n), .wr_i(h_mbox_wr), .wdata_i(h_wdata),
        .rd_i(l_mbox_rd), .data_o(h2l_data), .full_o(h2l_full)
    );

    mbox_chan #(.DW(DATA_W)) i_l2h (
        .clk(clk), .rst_n(rst_n), .wr_i(l_mbox_wr), .wdata_i(l_wdata),
        .rd_i(h_mbox_rd), .data_o(l2h_data), .full_o(l2h_full)
    );

    mbox_irq_side #(.DW(DATA_W)) i_host (
        .clk(clk), .rst_n(rst_n), .addr_i(h_addr), .wr_i(h_wr),
        .wbits_i(h_wdata[NSRC-1:0]), .mbox_full_i(l2h_full), .mbox_data_i(l2h_data),
        .ev_i(ev), .rdata_o(h_rdata), .irq_o(h_irq)
    );

    mbox_irq_side #(.DW(DATA_W)) i_local (
        .clk(clk), .rst_n(rst_n), .addr_i(l_addr), .wr_i(l_wr),
        .wbits_i(l_wdata[NSRC-1:0]), .mbox_full_i(h2l_full), .mbox_data_i(h2l_data),
        .ev_i(ev), .rdata_o(l_rdata), .irq_o(l_irq)
    );

    // R5
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_mbox_wr && l_mbox_rd) |=> h2l_full);
    // R3
    l2h_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_mbox_rd && !l_mbox_wr) |=> !l2h_full);
endmodule

// File: tb/test_mbox_irq_ctrl.sv
// Bench: directed mailbox and timing cases, then an exhaustive status x mask sweep on both sides.
module test_mbox_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  h_addr = '0, l_addr = '0;
    logic        h_wr = 1'b0, h_rd = 1'b0, l_wr = 1'b0, l_rd = 1'b0;
    logic [31:0] h_wdata = '0, l_wdata = '0;
    logic [31:0] h_rdata, l_rdata;
    logic        h_irq, l_irq;
    logic        dma_done = 1'b0, fifo_nempty = 1'b0, fifo_ovfl = 1'b0, ext_irq_pin = 1'b0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mbox_irq_ctrl i_mbox_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_irq(h_irq),
        .l_addr(l_addr), .l_wr(l_wr), .l_rd(l_rd), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_irq(l_irq),
        .dma_done(dma_done), .fifo_nempty(fifo_nempty), .fifo_ovfl(fifo_ovfl),
        .ext_irq_pin(ext_irq_pin)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Register write: one strobe cycle; returns just after the following negedge.
    task automatic wr(input bit side, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        if (!side) begin h_addr = a; h_wdata = d; h_wr = 1'b1; end
        else       begin l_addr = a; l_wdata = d; l_wr = 1'b1; end
        @(negedge clk);
        h_wr = 1'b0; l_wr = 1'b0;
    endtask

    // Mailbox read with strobe; samples the data before the clearing edge.
    task automatic rd_mbox(input bit side, output logic [31:0] q);
        @(negedge clk);
        if (!side) begin h_addr = 2'd0; h_rd = 1'b1; end
        else       begin l_addr = 2'd0; l_rd = 1'b1; end
        #1 q = side ? l_rdata : h_rdata;
        @(negedge clk);
        h_rd = 1'b0; l_rd = 1'b0;
    endtask

    // Side-effect-free look at a register, taken at the current time.
    task automatic peek(input bit side, input logic [1:0] a, output logic [31:0] q);
        if (!side) h_addr = a; else l_addr = a;
        #1 q = side ? l_rdata : h_rdata;
    endtask

    task automatic pulse_ev(input logic [2:0] e);
        @(negedge clk);
        {fifo_ovfl, fifo_nempty, dma_done} = e;
        @(negedge clk);
        {fifo_ovfl, fifo_nempty, dma_done} = 3'b000;
    endtask

    task automatic pulse_pin();
        @(negedge clk); ext_irq_pin = 1'b1;
        @(negedge clk); ext_irq_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_side(input bit side);
        logic [31:0] q;
        wr(side, 2'd1, 32'h1E);
        rd_mbox(side, q);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        peek(0, 2'd1, q); chk("R11 host status", q, 0);
        peek(1, 2'd1, q); chk("R11 local status", q, 0);
        peek(0, 2'd2, q); chk("R11 host mask", q, 0);
        peek(1, 2'd2, q); chk("R11 local mask", q, 0);
        peek(0, 2'd0, q); chk("R11 host mbox", q, 0);
        peek(1, 2'd0, q); chk("R11 local mbox", q, 0);
        chk("R11 irqs", {h_irq, l_irq}, 0);

        // R1 / R2 host to local
        wr(0, 2'd0, 32'hA5A5_0001);
        peek(1, 2'd1, q); chk("R1 local flag", q, 1);
        peek(0, 2'd1, q); chk("R1 host flag untouched", q, 0);
        rd_mbox(1, q);    chk("R1 local data", q, 32'hA5A5_0001);
        peek(1, 2'd1, q); chk("R2 flag cleared", q, 0);
        peek(1, 2'd0, q); chk("R2 data kept", q, 32'hA5A5_0001);

        // R3 local to host
        wr(1, 2'd0, 32'h1234_5678);
        peek(0, 2'd1, q); chk("R3 host flag", q, 1);
        rd_mbox(0, q);    chk("R3 host data", q, 32'h1234_5678);
        peek(0, 2'd1, q); chk("R3 host flag cleared", q, 0);

        // R4 overwrite before read
        wr(0, 2'd0, 32'h0000_00AA);
        wr(0, 2'd0, 32'h0000_00BB);
        peek(1, 2'd1, q); chk("R4 flag stays", q, 1);
        rd_mbox(1, q);    chk("R4 newest data", q, 32'h0000_00BB);
        peek(1, 2'd1, q); chk("R4 flag cleared", q, 0);

        // R5 write and read in one cycle
        wr(0, 2'd0, 32'h0000_0C01);
        @(negedge clk);
        h_addr = 2'd0; h_wdata = 32'h0000_0C02; h_wr = 1'b1;
        l_addr = 2'd0; l_rd = 1'b1;
        #1 chk("R5 old data read", l_rdata, 32'h0000_0C01);
        @(negedge clk);
        h_wr = 1'b0; l_rd = 1'b0;
        peek(1, 2'd1, q); chk("R5 flag stays", q, 1);
        peek(1, 2'd0, q); chk("R5 new data", q, 32'h0000_0C02);
        rd_mbox(1, q);

        // R6 events are sticky on both sides
        pulse_ev(3'b111);
        repeat (2) @(negedge clk);
        peek(0, 2'd1, q); chk("R6 host events", q, 32'h0E);
        peek(1, 2'd1, q); chk("R6 local events", q, 32'h0E);

        // R7 zero bits keep; ones clear; bit 0 ignores
        wr(1, 2'd0, 32'h7);                 // host status bit 0 set
        wr(0, 2'd1, 32'h0);
        peek(0, 2'd1, q); chk("R7 zero write no effect", q, 32'h0F);
        wr(0, 2'd1, 32'h05);
        peek(0, 2'd1, q); chk("R7 w1c bit2, bit0 kept", q, 32'h0B);
        // R12 local unaffected by host clear
        peek(1, 2'd1, q); chk("R12 local status kept", q, 32'h0E);

        // R8 event coincides with clear
        @(negedge clk);
        h_addr = 2'd1; h_wdata = 32'h02; h_wr = 1'b1; dma_done = 1'b1;
        @(negedge clk);
        h_wr = 1'b0; dma_done = 1'b0;
        peek(0, 2'd1, q); chk("R8 event wins", q, 32'h0B);
        clear_side(0); clear_side(1);

        // R9 synchronizer latency and hold-high behaviour
        @(negedge clk); ext_irq_pin = 1'b1;
        repeat (2) @(negedge clk);
        peek(0, 2'd1, q); chk("R9 not yet after 2 edges", q, 0);
        @(negedge clk);
        peek(0, 2'd1, q); chk("R9 set after 3 edges", q, 32'h10);
        wr(0, 2'd1, 32'h10);
        repeat (4) @(negedge clk);
        peek(0, 2'd1, q); chk("R9 no re-set while held", q, 0);
        ext_irq_pin = 1'b0;
        repeat (4) @(negedge clk);
        clear_side(1);

        // R10 mask readback and R12 mask independence
        wr(0, 2'd2, 32'hFFFF_FFF5);
        peek(0, 2'd2, q); chk("R10 mask readback", q, 32'h15);
        peek(1, 2'd2, q); chk("R12 local mask kept", q, 0);

        // R10 exhaustive status x mask sweep on each side
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 32; p++) begin
                clear_side(s[0]);
                if (p[0]) wr(~s[0], 2'd0, 32'(p));
                if (p[3:1] != 0) pulse_ev(p[3:1]);
                if (p[4]) pulse_pin();
                peek(s[0], 2'd1, q); chk("R6 R9 sweep pattern", q, 32'(p));
                for (int m = 0; m < 32; m++) begin
                    wr(s[0], 2'd2, 32'(m));
                    chk("R10 irq combine", 32'(s ? l_irq : h_irq), 32'(((p & m) != 0)));
                end
            end
        end

        summary();
    end
endmodule